// File: doc/BRIEF.md
# DMA Channel Event Interrupt Collector

This block gathers single-cycle event pulses from a set of DMA channels and sorts them into four interrupt classes: transfer done, source-side error, destination-side error and configuration error. Every class keeps one latched bit per channel. Bit i of every class word belongs to channel i. Software sees each class twice. One window is read-only. The other clears bits when software writes ones to it. The block also drives one combined interrupt line.

Software accesses the block through a simple register bus with single-cycle write and read strobes. To service an interrupt, software reads the class words and handles the set bits from the lowest channel upward. It then writes exactly the bits it handled back to the clear window of that class. Writing all ones to every clear window empties the whole block.

The same register space also holds three more words. The first is a busy word, with one bit per channel taken from the channels. A channel whose busy bit is set must not be given a new transfer. The other two are a group-priority word and an arbitration word that software can read and write. Writing zero to the arbitration word gives all channels equal priority.

Top module: `dma_irq_unit`

## Requirements
- R1: A pulse on a channel's event input sets that channel's bit in the matching class latch at the next clock edge. The bit stays set until it is cleared. Classes are indexed done=0, source error=1, destination error=2, configuration error=3.
- R2: A write to the clear window of class c, at offset 0x810 + 4*c, clears every latched bit of that class whose data bit is 1. Bits whose data bit is 0 keep their value.
- R3: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R4: Reads at offset 0x800 + 4*c return the latched bits of class c in bits [NUM_CH-1:0], with zeros above them. Reads of the clear window return the same contents. Writes to 0x800..0x80C change nothing.
- R5: A read of offset 0x820 returns the `ch_busy` input, with channel i in bit i.
- R6: The group-priority word at 0x824 and the arbitration word at 0x828 are read/write and full width. Each drives its own output. Neither changes unless it is written.
- R7: `irq` is the OR of all latched bits across all four classes, delayed by one register. It rises two edges after the event pulse is sampled and falls one edge after the clearing write takes effect.
- R8: Reads of any offset not listed in R4, R5 and R6 return zero.
- R9: Reset clears all latches, both configuration words, `rdata` and `irq`.
- R10: `rdata` is registered. It takes the read value at the edge where `rd_en` is sampled high and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_done | input | NUM_CH | Transfer-done pulses, one per channel |
| evt_src_err | input | NUM_CH | Source-error pulses |
| evt_dst_err | input | NUM_CH | Destination-error pulses |
| evt_cfg_err | input | NUM_CH | Configuration-error pulses |
| ch_busy | input | NUM_CH | Busy level of each channel |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| grp_prio | output | DATA_W | Group-priority word |
| arb_cfg | output | DATA_W | Arbitration word |
| irq | output | 1 | Combined interrupt |

## Verification
The bench checks several corner cases and what a faulty design would show in each:
- A pulse and a clear on the same bit in the same cycle: if the clear won, the bench would read the bit as zero and the event would be lost.
- A write of zeros to a clear window, and a write of all ones to the read-only window: a wrong decode or wrong clear polarity would wipe latched events.
- The lowest and highest channel bits are exercised in separate classes, so a shifted or swapped class would appear as a wrong value at a read.
- The interrupt line is checked on both sides of its extra register. A design with no register, or with two, would assert one cycle early or late.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int NCLASS = 4;
   localparam int unsigned OFS_STAT  = 32'h800;
   localparam int unsigned OFS_RAW   = 32'h810;
   localparam int unsigned OFS_BUSY  = 32'h820;
   localparam int unsigned OFS_GPRIO = 32'h824;
   localparam int unsigned OFS_ARB   = 32'h828;
   localparam int unsigned MIN_ADDR_W = 12;
endpackage

// File: rtl/dma_irq_latch.sv
module dma_irq_latch #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic              clr_en,
   input  logic [NUM_CH-1:0] clr_mask,
   output logic [NUM_CH-1:0] q
);
   logic [NUM_CH-1:0] kill;

   assign kill = clr_en ? clr_mask : '0;

   // set has priority over a same-cycle clear
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~kill) | set_i;
   end
endmodule

// File: rtl/dma_irq_regfile.sv
module dma_irq_regfile
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          rd_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [NCLASS-1:0][NUM_CH-1:0] lat,
   input  logic [NUM_CH-1:0]             busy,
   output logic [NCLASS-1:0]             clr_en,
   output logic [DATA_W-1:0]             prio_q,
   output logic [DATA_W-1:0]             arb_q,
   output logic [DATA_W-1:0]             rdata
);
   localparam logic [ADDR_W-1:0] A_BUSY  = ADDR_W'(OFS_BUSY);
   localparam logic [ADDR_W-1:0] A_GPRIO = ADDR_W'(OFS_GPRIO);
   localparam logic [ADDR_W-1:0] A_ARB   = ADDR_W'(OFS_ARB);

   logic [DATA_W-1:0] rd_nxt;

   genvar gc;
   generate
      for (gc = 0; gc < NCLASS; gc++) begin : g_clr
         assign clr_en[gc] = wr_en && (addr == ADDR_W'(OFS_RAW + 4 * gc));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_q <= '0;
         arb_q  <= '0;
      end else if (wr_en) begin
         if (addr == A_GPRIO) prio_q <= wdata;
         if (addr == A_ARB)   arb_q  <= wdata;
      end
   end

   always_comb begin
      rd_nxt = '0;
      for (int c = 0; c < NCLASS; c++) begin
         if (addr == ADDR_W'(OFS_STAT + 4 * c) || addr == ADDR_W'(OFS_RAW + 4 * c))
            rd_nxt[NUM_CH-1:0] = lat[c];
      end
      if (addr == A_BUSY)  rd_nxt[NUM_CH-1:0] = busy;
      if (addr == A_GPRIO) rd_nxt = prio_q;
      if (addr == A_ARB)   rd_nxt = arb_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_nxt;
   end
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NCLASS-1:0][NUM_CH-1:0] lat,
   output logic                          irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |lat;
   end
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt_done,
   input  logic [NUM_CH-1:0] evt_src_err,
   input  logic [NUM_CH-1:0] evt_dst_err,
   input  logic [NUM_CH-1:0] evt_cfg_err,
   input  logic [NUM_CH-1:0] ch_busy,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] grp_prio,
   output logic [DATA_W-1:0] arb_cfg,
   output logic              irq
);
   generate
      if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
         $error("NUM_CH must lie in 1..DATA_W");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NCLASS-1:0][NUM_CH-1:0] evt_all;
   logic [NCLASS-1:0][NUM_CH-1:0] lat_q;
   logic [NCLASS-1:0]             clr_en;

   assign evt_all = {evt_cfg_err, evt_dst_err, evt_src_err, evt_done};

   genvar gc;
   generate
      for (gc = 0; gc < NCLASS; gc++) begin : g_cls
         dma_irq_latch #(.NUM_CH(NUM_CH)) u_lat (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (evt_all[gc]),
            .clr_en   (clr_en[gc]),
            .clr_mask (wdata[NUM_CH-1:0]),
            .q        (lat_q[gc])
         );
      end
   endgenerate

   dma_irq_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .addr   (addr),
      .wdata  (wdata),
      .lat    (lat_q),
      .busy   (ch_busy),
      .clr_en (clr_en),
      .prio_q (grp_prio),
      .arb_q  (arb_cfg),
      .rdata  (rdata)
   );

   dma_irq_merge #(.NUM_CH(NUM_CH)) u_merge (
      .clk   (clk),
      .rst_n (rst_n),
      .lat   (lat_q),
      .irq   (irq)
   );
endmodule

// File: rtl/dma_irq_unit_chk.sv
module dma_irq_unit_chk
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NCLASS-1:0][NUM_CH-1:0] evt_all,
   input logic [NCLASS-1:0][NUM_CH-1:0] lat_q,
   input logic                          wr_en,
   input logic [ADDR_W-1:0]             addr,
   input logic [DATA_W-1:0]             wdata,
   input logic [DATA_W-1:0]             arb_cfg,
   input logic                          irq
);
   genvar gc;
   generate
      for (gc = 0; gc < NCLASS; gc++) begin : g_a
         AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
            (|evt_all[gc]) |=> ((lat_q[gc] & $past(evt_all[gc])) == $past(evt_all[gc]))); // R3
         AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_all[gc] == '0) |=> ((lat_q[gc] & ~$past(lat_q[gc])) == '0)); // R1
         AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(OFS_RAW + 4 * gc))
            |=> ((lat_q[gc] & $past(wdata[NUM_CH-1:0]) & ~$past(evt_all[gc])) == '0)); // R2
         AST_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(OFS_STAT + 4 * gc) && evt_all[gc] == '0)
            |=> $stable(lat_q[gc])); // R4
      end
   endgenerate

   AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_all) |-> ##2 irq); // R7
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q == '0) |=> !irq); // R7
   AST_ARB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(arb_cfg)); // R6
endmodule

bind dma_irq_unit dma_irq_unit_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt_all (evt_all),
   .lat_q   (lat_q),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .arb_cfg (arb_cfg),
   .irq     (irq)
);

// File: tb/dma_irq_unit_bench.sv
`timescale 1ns/1ps
module dma_irq_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ed = '0, es = '0, edd = '0, ec = '0, busy = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, grp_prio, arb_cfg;
   logic        irq;
   int          n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   dma_irq_unit u_dma_irq_unit (
      .clk(clk), .rst_n(rst_n), .evt_done(ed), .evt_src_err(es),
      .evt_dst_err(edd), .evt_cfg_err(ec), .ch_busy(busy),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .grp_prio(grp_prio), .arb_cfg(arb_cfg), .irq(irq)
   );

   // {class, pulse mask, clear mask, expected class word}
   localparam logic [25:0] VEC [10] = '{
      {2'd0, 8'h01, 8'h00, 8'h01},
      {2'd0, 8'h80, 8'h00, 8'h81},
      {2'd0, 8'h00, 8'h01, 8'h80},
      {2'd1, 8'h0F, 8'h05, 8'h0A},
      {2'd2, 8'hF0, 8'h00, 8'hF0},
      {2'd2, 8'h00, 8'hFF, 8'h00},
      {2'd3, 8'h3C, 8'h00, 8'h3C},
      {2'd3, 8'h00, 8'h00, 8'h3C},
      {2'd1, 8'h00, 8'h0A, 8'h00},
      {2'd0, 8'h00, 8'h80, 8'h00}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_evt(input logic [1:0] cls, input logic [7:0] m);
      case (cls)
         2'd0: ed = m;
         2'd1: es = m;
         2'd2: edd = m;
         default: ec = m;
      endcase
   endtask

   task automatic pulse(input logic [1:0] cls, input logic [7:0] m);
      set_evt(cls, m);
      @(negedge clk);
      ed = '0; es = '0; edd = '0; ec = '0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 irq", {31'd0, irq}, 32'd0);
      chk("R9 rdata", rdata, 32'd0);
      chk("R9 grp_prio", grp_prio, 32'd0);
      chk("R9 arb_cfg", arb_cfg, 32'd0);
      rd(12'h80C, r); chk("R9 latch", r, 32'd0);

      // table walk: R1 latching, R2 clearing, R4 read of class word
      for (int i = 0; i < 10; i++) begin
         logic [25:0] v;
         v = VEC[i];
         pulse(v[25:24], v[23:16]);
         wr(12'(12'h810 + 4 * v[25:24]), {24'd0, v[15:8]});
         rd(12'(12'h800 + 4 * v[25:24]), r);
         chk("R1 R2 class word", r, {24'd0, v[7:0]});
      end
      rd(12'h81C, r); chk("R4 clear window read", r, 32'h3C);
      wr(12'h81C, 32'hFFFF_FFFF);
      rd(12'h80C, r); chk("R2 all-ones clear", r, 32'd0);

      // R4 writes to read-only words ignored
      pulse(2'd0, 8'h08);
      wr(12'h800, 32'hFFFF_FFFF);
      rd(12'h800, r); chk("R4 status write ignored", r, 32'h08);
      wr(12'h810, 32'h08);
      rd(12'h800, r); chk("R2 cleared", r, 32'd0);

      // R3 same-cycle set and clear
      set_evt(2'd1, 8'h04);
      wr(12'h814, 32'h04);
      es = '0;
      rd(12'h804, r); chk("R3 set wins", r, 32'h04);
      wr(12'h814, 32'h04);
      rd(12'h804, r); chk("R3 later clear", r, 32'd0);

      // R5 busy word
      busy = 8'h5A;
      rd(12'h820, r); chk("R5 busy", r, 32'h5A);
      busy = '0;

      // R10 hold
      repeat (3) @(negedge clk);
      chk("R10 rdata holds", rdata, 32'h5A);

      // R6 config words
      wr(12'h824, 32'h1234_5678);
      chk("R6 grp_prio out", grp_prio, 32'h1234_5678);
      wr(12'h828, 32'hABCD_0001);
      chk("R6 arb out", arb_cfg, 32'hABCD_0001);
      rd(12'h824, r); chk("R6 grp_prio read", r, 32'h1234_5678);
      wr(12'h828, 32'd0);
      rd(12'h828, r); chk("R6 arb zero", r, 32'd0);

      // R8 unmapped
      rd(12'h824, r);
      rd(12'h830, r); chk("R8 unmapped 0x830", r, 32'd0);
      rd(12'h824, r);
      rd(12'h7FC, r); chk("R8 unmapped 0x7FC", r, 32'd0);

      // R7 irq timing
      pulse(2'd1, 8'h40);
      chk("R7 irq not yet", {31'd0, irq}, 32'd0);
      @(negedge clk);
      chk("R7 irq up", {31'd0, irq}, 32'd1);
      wr(12'h814, 32'h40);
      chk("R7 irq still up", {31'd0, irq}, 32'd1);
      @(negedge clk);
      chk("R7 irq down", {31'd0, irq}, 32'd0);

      summary();
   end
endmodule